// File: doc/BRIEF.md
# Region-Decoded Data Memory with Keyboard Word

This block is the data memory of a small 16-bit machine. One word address picks one of three regions. The lower half of the address space is general-purpose RAM. The next quarter is a screen buffer. The first word of the top quarter is a single keyboard word, which shows a key code supplied from outside. Every other address in the top quarter is invalid. Reads are combinational, so the read word always follows the current address. A write takes effect at the clock edge, and the new value is visible from the following cycle.

The screen buffer has a second read-only port with its own word index, so a display engine can fetch pixels at any time without disturbing the main port. The address width is the parameter `ADDR_W`. With `ADDR_W = 15` the map is: RAM at 0x0000–0x3FFF, screen at 0x4000–0x5FFF, keyboard at 0x6000, and invalid above 0x6000. The default `ADDR_W = 12` keeps the same map at one eighth of the size: RAM at 0x000–0x7FF, screen at 0x800–0xBFF, keyboard at 0xC00, and invalid from 0xC01 to 0xFFF. All addresses below use the default size.

Top module: `mmio_memory`

## Requirements
- R1: An address with its top bit clear (0x000–0x7FF) selects the RAM. A word written there reads back at the same address, including the last RAM word 0x7FF.
- R2: An address whose top two bits are 10 (0x800–0xBFF) selects the screen buffer, which is separate storage read and written through the main port.
- R3: When `wr_en` is high at a rising clock edge, `wr_data` is stored at the address presented in that cycle. Before that edge the read word still shows the old value. From the next cycle on it shows the new value.
- R4: `rd_data` is combinational. A change of `addr` changes `rd_data` within the same cycle, with no clock edge.
- R5: Address 0xC00 returns `key_code` combinationally, including changes of `key_code` made between clock edges and values present while `rst` is high.
- R6: Any address from 0xC01 to 0xFFF reads as 0x0000.
- R7: A write to 0xC00 or to any invalid address changes no RAM word and no screen word, including the words whose low address bits match.
- R8: `disp_idx` reads screen word `disp_idx` on `disp_data` combinationally, at the same time as, and independent of, the main port's address.
- R9: A write requested while `rst` is high is ignored. `rst` does not clear the stored words.
- R10: A write to the screen at index k leaves RAM word k unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes happen on its rising edge |
| rst | input | 1 | Synchronous active-high reset; blocks writes |
| wr_en | input | 1 | Write request for the current cycle |
| addr | input | ADDR_W | Word address of the main port |
| wr_data | input | DATA_W | Word to store |
| key_code | input | DATA_W | Key code from outside, returned at the keyboard address |
| rd_data | output | DATA_W | Word at `addr` (combinational) |
| disp_idx | input | ADDR_W-2 | Screen word index of the display read port |
| disp_data | output | DATA_W | Screen word at `disp_idx` (combinational) |

## Verification
A decode fault shows up on the first read of the wrong region. Writes that land in the wrong bank, or that leak from invalid addresses, show up one cycle later, when the aliased word is read back through either port. The bench writes distinct values at the region edges and at aliasing offsets, then reads them back. A wrong read mux or a stale keyboard path is seen in the same cycle, because all reads are combinational.

// File: rtl/mm_pkg.sv
package mm_pkg;

  typedef enum logic [1:0] {
    RGN_RAM = 2'd0,
    RGN_SCR = 2'd1,
    RGN_KEY = 2'd2,
    RGN_BAD = 2'd3
  } region_e;

endpackage

// File: rtl/mm_addr_decode.sv
module mm_addr_decode
  import mm_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region
);

  localparam int LOW_W = ADDR_W - 2;

  logic [1:0]       top_bits;
  logic [LOW_W-1:0] low_bits;

  assign top_bits = addr[ADDR_W-1:ADDR_W-2];
  assign low_bits = addr[LOW_W-1:0];

  always_comb begin
    if (!top_bits[1])           region = RGN_RAM;
    else if (top_bits == 2'b10) region = RGN_SCR;
    else if (low_bits == '0)    region = RGN_KEY;
    else                        region = RGN_BAD;
  end

endmodule

// File: rtl/mm_word_bank.sv
module mm_word_bank #(
  parameter int AW       = 10,
  parameter int DW       = 16,
  parameter int RD_PORTS = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_idx  [RD_PORTS],
  output logic [DW-1:0] rd_data [RD_PORTS]
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];
  logic          wr_ok;

  assign wr_ok = wr_en && !rst;

  always_ff @(posedge clk) begin
    if (wr_ok) store[wr_idx] <= wr_data;
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    assign rd_data[p] = store[rd_idx[p]];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
      (wr_ok && rd_idx[p] == wr_idx) |=> ($stable(rd_idx[p]) |-> rd_data[p] == $past(wr_data))) // R3
      else $error("bank write not visible on read port");
  end

endmodule

// File: rtl/mm_read_mux.sv
module mm_read_mux
  import mm_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  region_e       region,
  input  logic [DW-1:0] ram_word,
  input  logic [DW-1:0] scr_word,
  input  logic [DW-1:0] key_word,
  output logic [DW-1:0] rd_word
);

  always_comb begin
    unique case (region)
      RGN_RAM: rd_word = ram_word;
      RGN_SCR: rd_word = scr_word;
      RGN_KEY: rd_word = key_word;
      default: rd_word = '0;
    endcase
  end

  AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (rst)
    (region == RGN_BAD) |-> (rd_word == '0)) // R6
    else $error("invalid address read nonzero");

  AST_KEY_LIVE: assert property (@(posedge clk) disable iff (rst)
    (region == RGN_KEY) |-> (rd_word == key_word)) // R5
    else $error("keyboard word not passed through");

endmodule

// File: rtl/mmio_memory.sv
module mmio_memory
  import mm_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] key_code,
  output logic [DATA_W-1:0] rd_data,
  input  logic [ADDR_W-3:0] disp_idx,
  output logic [DATA_W-1:0] disp_data
);

  localparam int RAM_AW = ADDR_W - 1;
  localparam int SCR_AW = ADDR_W - 2;

  region_e     region;
  logic        ram_we;
  logic        scr_we;
  logic [RAM_AW-1:0] ram_idx;
  logic [SCR_AW-1:0] scr_idx;
  logic [RAM_AW-1:0] ram_rd_idx  [1];
  logic [DATA_W-1:0] ram_rd_data [1];
  logic [SCR_AW-1:0] scr_rd_idx  [2];
  logic [DATA_W-1:0] scr_rd_data [2];

  mm_addr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr   (addr),
    .region (region)
  );

  assign ram_idx = addr[RAM_AW-1:0];
  assign scr_idx = addr[SCR_AW-1:0];
  assign ram_we  = wr_en && (region == RGN_RAM);
  assign scr_we  = wr_en && (region == RGN_SCR);

  assign ram_rd_idx[0] = ram_idx;
  assign scr_rd_idx[0] = scr_idx;
  assign scr_rd_idx[1] = disp_idx;

  mm_word_bank #(.AW(RAM_AW), .DW(DATA_W), .RD_PORTS(1)) u_ram (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (ram_we),
    .wr_idx  (ram_idx),
    .wr_data (wr_data),
    .rd_idx  (ram_rd_idx),
    .rd_data (ram_rd_data)
  );

  mm_word_bank #(.AW(SCR_AW), .DW(DATA_W), .RD_PORTS(2)) u_screen (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (scr_we),
    .wr_idx  (scr_idx),
    .wr_data (wr_data),
    .rd_idx  (scr_rd_idx),
    .rd_data (scr_rd_data)
  );

  mm_read_mux #(.DW(DATA_W)) u_rmux (
    .clk      (clk),
    .rst      (rst),
    .region   (region),
    .ram_word (ram_rd_data[0]),
    .scr_word (scr_rd_data[0]),
    .key_word (key_code),
    .rd_word  (rd_data)
  );

  assign disp_data = scr_rd_data[1];

  AST_DISP_SEES_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr[ADDR_W-1:ADDR_W-2] == 2'b10 && disp_idx == addr[SCR_AW-1:0])
    |=> ($stable(disp_idx) |-> disp_data == $past(wr_data))) // R8
    else $error("display port missed screen write");

  AST_RAM_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !addr[ADDR_W-1]) |=> ($stable(addr) |-> rd_data == $past(wr_data))) // R1
    else $error("RAM write not visible");

endmodule

// File: tb/mmio_memory_bench.sv
module mmio_memory_bench;

  localparam int AW = 12;
  localparam int DW = 16;
  localparam int NV = 20;

  // {check, we, 2'b0, addr[11:0], wdata, key, expected}
  localparam logic [63:0] VEC [NV] = '{
    {1'b0, 1'b1, 2'b0, 12'h000, 16'h1111, 16'h0000, 16'h0000},
    {1'b1, 1'b0, 2'b0, 12'h000, 16'h0000, 16'h0000, 16'h1111},
    {1'b0, 1'b1, 2'b0, 12'h7FF, 16'hA5A5, 16'h0000, 16'h0000},
    {1'b1, 1'b0, 2'b0, 12'h7FF, 16'h0000, 16'h0000, 16'hA5A5},
    {1'b0, 1'b1, 2'b0, 12'h800, 16'h2222, 16'h0000, 16'h0000},
    {1'b1, 1'b0, 2'b0, 12'h800, 16'h0000, 16'h0000, 16'h2222},
    {1'b0, 1'b1, 2'b0, 12'hBFF, 16'hBEEF, 16'h0000, 16'h0000},
    {1'b1, 1'b0, 2'b0, 12'hBFF, 16'h0000, 16'h0000, 16'hBEEF},
    {1'b1, 1'b0, 2'b0, 12'h000, 16'h0000, 16'h0000, 16'h1111},
    {1'b1, 1'b0, 2'b0, 12'hC00, 16'h0000, 16'h0041, 16'h0041},
    {1'b1, 1'b1, 2'b0, 12'hC00, 16'hFFFF, 16'h0042, 16'h0042},
    {1'b1, 1'b0, 2'b0, 12'h000, 16'h0000, 16'h0000, 16'h1111},
    {1'b1, 1'b0, 2'b0, 12'h800, 16'h0000, 16'h0000, 16'h2222},
    {1'b1, 1'b1, 2'b0, 12'hC01, 16'h7777, 16'h0000, 16'h0000},
    {1'b1, 1'b1, 2'b0, 12'hFFF, 16'h7777, 16'h0000, 16'h0000},
    {1'b1, 1'b0, 2'b0, 12'h7FF, 16'h0000, 16'h0000, 16'hA5A5},
    {1'b1, 1'b0, 2'b0, 12'hBFF, 16'h0000, 16'h0000, 16'hBEEF},
    {1'b0, 1'b1, 2'b0, 12'h010, 16'h0123, 16'h0000, 16'h0000},
    {1'b1, 1'b1, 2'b0, 12'h010, 16'h0456, 16'h0000, 16'h0123},
    {1'b1, 1'b0, 2'b0, 12'h010, 16'h0000, 16'h0000, 16'h0456}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] key_code = '0;
  logic [DW-1:0] rd_data;
  logic [AW-3:0] disp_idx = '0;
  logic [DW-1:0] disp_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mmio_memory #(.ADDR_W(AW), .DATA_W(DW)) u_mmio_memory (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .addr      (addr),
    .wr_data   (wr_data),
    .key_code  (key_code),
    .rd_data   (rd_data),
    .disp_idx  (disp_idx),
    .disp_data (disp_data)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %04h expected %04h", req, act, exp);
    end
  endtask

  function automatic string vec_tag(input int i);
    case (i)
      1:          return "R3 RAM first write";
      3:          return "R1 last RAM word";
      5, 7:       return "R2 screen region";
      8:          return "R10 RAM untouched by screen";
      9, 10:      return "R5 keyboard word";
      11, 12, 15, 16: return "R7 aliases unchanged";
      13, 14:     return "R6 invalid reads zero";
      default:    return "R3 write timing";
    endcase
  endfunction

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // reset state: keyboard and invalid reads already defined under reset
    @(negedge clk);
    addr = 12'hC00; key_code = 16'h1234;
    #1 check("R5 reset key", rd_data, 16'h1234);
    addr = 12'hD00;
    #1 check("R6 reset invalid", rd_data, 16'h0000);
    @(negedge clk);
    rst = 1'b0;

    // table walk: check before the edge, write lands on the edge
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      wr_en    = VEC[i][62];
      addr     = VEC[i][59:48];
      wr_data  = VEC[i][47:32];
      key_code = VEC[i][31:16];
      #1;
      if (VEC[i][63]) check(vec_tag(i), rd_data, VEC[i][15:0]);
    end
    @(negedge clk);
    wr_en = 1'b0;

    // R4: address change without a clock edge
    addr = 12'h000;
    #1 check("R4 comb read RAM", rd_data, 16'h1111);
    addr = 12'h800;
    #1 check("R4 comb read screen", rd_data, 16'h2222);

    // R5: key code change between edges
    addr = 12'hC00; key_code = 16'h00AA;
    #1 check("R5 live key", rd_data, 16'h00AA);

    // R8: display port independent of main port
    addr = 12'h000; disp_idx = 10'h3FF;
    #1 check("R8 display port", disp_data, 16'hBEEF);
    check("R8 main port concurrent", rd_data, 16'h1111);
    disp_idx = 10'h000;
    #1 check("R8 display index 0", disp_data, 16'h2222);

    // R7: writes to keyboard/invalid left screen alias intact
    disp_idx = 10'h001;
    @(negedge clk);
    wr_en = 1'b1; addr = 12'h801; wr_data = 16'h3333;
    @(negedge clk);
    wr_en = 1'b1; addr = 12'hC01; wr_data = 16'h9999;
    @(negedge clk);
    wr_en = 1'b0;
    #1 check("R7 display alias unchanged", disp_data, 16'h3333);

    // R9: write under reset ignored, contents kept
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b1; addr = 12'h000; wr_data = 16'hDEAD;
    @(negedge clk);
    rst = 1'b0; wr_en = 1'b0;
    #1 check("R9 write under reset ignored", rd_data, 16'h1111);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule